// File: doc/BRIEF.md
# Load-Linked / Store-Conditional Reservation Monitor

This block holds one processor's atomic reservation. A load-linked request saves its address in a link register and sets a valid flag. A later store-conditional asks whether the reservation is still intact. The block answers in the same cycle with an acknowledge strobe, a pass/fail bit and a store write-enable that is gated by that answer. The store's data path, the cache arrays and the coherence protocol stay outside the block.

The reservation can be lost in four ways:
- an interrupt or context-switch pulse,
- a coherence invalidation whose cache block equals the linked block (for example, one caused by another processor's successful store-conditional),
- any store-conditional, whether it passes or fails,
- a newer load-linked, which replaces it.

Addresses are compared at cache-block granularity. The low `BLK_OFS_W` bits are the byte offset inside a block and are ignored.

Top module: `resv_monitor`

## Requirements
- R1: After reset, `link_vld` is 0 and `link_addr` is 0.
- R2: A load-linked request with no interrupt in the same cycle sets `link_vld` to 1 and stores `ll_addr` in `link_addr` from the next cycle on.
- R3: A store-conditional passes when the reservation is valid and the block bits of `sc_addr` equal the block bits of `link_addr`. A pass drives `sc_ack`=1, `sc_pass`=1 and `st_we`=1 in the request cycle.
- R4: A store-conditional to a different block, or with no valid reservation, gives `sc_ack`=1, `sc_pass`=0 and `st_we`=0.
- R5: Every store-conditional clears `link_vld` for the next cycle, whether it passes or fails, unless a load-linked arrives in the same cycle.
- R6: An interrupt pulse clears `link_vld` for the next cycle. A store-conditional in the same cycle as the interrupt fails.
- R7: An invalidation whose block bits equal those of `link_addr` clears `link_vld`. An invalidation to any other block leaves `link_vld` and `link_addr` unchanged.
- R8: When a matching invalidation and a matching store-conditional arrive in the same cycle, the store-conditional fails.
- R9: A new load-linked replaces an existing reservation. A store-conditional to the old block then fails.
- R10: The byte-offset bits (the low `BLK_OFS_W` bits) take no part in matching. A store-conditional to another byte of the linked block passes.
- R11: When a load-linked and an interrupt arrive in the same cycle, the interrupt wins and `link_vld` is 0 in the next cycle.
- R12: Without a store-conditional request, `sc_ack`, `sc_pass` and `st_we` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ll_req | input | 1 | Load-linked request |
| ll_addr | input | ADDR_W | Load-linked address |
| sc_req | input | 1 | Store-conditional request |
| sc_addr | input | ADDR_W | Store-conditional address |
| irq | input | 1 | Interrupt / context-switch pulse |
| inval_vld | input | 1 | Coherence invalidation strobe |
| inval_addr | input | ADDR_W | Address of the invalidated block |
| sc_ack | output | 1 | Store-conditional answered this cycle |
| sc_pass | output | 1 | 1 = success, 0 = failure |
| st_we | output | 1 | Store write-enable, gated by success |
| link_vld | output | 1 | Reservation valid flag |
| link_addr | output | ADDR_W | Stored load-linked address |

## Verification
The bench builds the monitor with `ADDR_W`=16 and `BLK_OFS_W`=4, so a block is 16 bytes. With these values a test can pick two addresses in the same block that differ only in the low nibble, or two neighbouring blocks that differ only in bit 4, and then show that matching depends only on the block bits. The short address also makes it cheap to place a load-linked, a store-conditional, an interrupt and an invalidation in one cycle, which covers every priority rule between them.

// File: rtl/resv_pkg.sv
package resv_pkg;
  // Action applied to the link register at the next clock edge
  typedef enum logic [1:0] {
    ACT_HOLD  = 2'd0,
    ACT_SET   = 2'd1,
    ACT_CLEAR = 2'd2
  } resv_act_e;
endpackage

// File: rtl/resv_blk_cmp.sv
module resv_blk_cmp #(
  parameter int ADDR_W    = 32,
  parameter int BLK_OFS_W = 6
) (
  input  logic [ADDR_W-1:0] a_addr,
  input  logic [ADDR_W-1:0] b_addr,
  output logic              same_blk
);
  localparam int BLK_W = ADDR_W - BLK_OFS_W;

  generate
    if (BLK_OFS_W == 0) begin : g_full
      assign same_blk = (a_addr == b_addr);
    end else begin : g_blk
      logic [BLK_W-1:0] a_blk, b_blk;
      logic [BLK_OFS_W-1:0] unused_ofs;
      assign a_blk      = a_addr[ADDR_W-1:BLK_OFS_W];
      assign b_blk      = b_addr[ADDR_W-1:BLK_OFS_W];
      assign unused_ofs = a_addr[BLK_OFS_W-1:0] ^ b_addr[BLK_OFS_W-1:0];
      assign same_blk   = (a_blk == b_blk);
    end
  endgenerate
endmodule

// File: rtl/resv_ctrl.sv
module resv_ctrl
  import resv_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      ll_req,
  input  logic      sc_req,
  input  logic      irq,
  input  logic      inval_vld,
  input  logic      link_vld,
  input  logic      sc_blk_eq,
  input  logic      inval_blk_eq,
  output logic      sc_ack,
  output logic      sc_pass,
  output resv_act_e act
);
  logic sc_hit;
  logic inval_hit;

  always_comb begin
    sc_hit    = link_vld & sc_blk_eq;
    inval_hit = inval_vld & link_vld & inval_blk_eq;
    sc_ack    = sc_req;
    sc_pass   = sc_req & sc_hit & ~inval_hit & ~irq;
  end

  // Priority: interrupt, then new link, then any consuming event
  always_comb begin
    if (irq)                        act = ACT_CLEAR;
    else if (ll_req)                act = ACT_SET;
    else if (sc_req || inval_hit)   act = ACT_CLEAR;
    else                            act = ACT_HOLD;
  end

  // R3: a pass requires a live reservation
  p_pass_needs_link_r3: assert property (@(posedge clk) disable iff (!rst_n)
    sc_pass |-> link_vld);

  // R8: a colliding invalidation makes the store-conditional fail
  p_inval_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (inval_vld && inval_blk_eq && link_vld) |-> !sc_pass);

  // R12: no answer without a request
  p_idle_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !sc_req |-> (!sc_ack && !sc_pass));
endmodule

// File: rtl/resv_link_reg.sv
module resv_link_reg
  import resv_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  resv_act_e         act,
  input  logic [ADDR_W-1:0] ll_addr,
  output logic              link_vld,
  output logic [ADDR_W-1:0] link_addr
);
  logic              vld_d;
  logic [ADDR_W-1:0] addr_d;
  logic              vld_en;
  logic              addr_en;

  always_comb begin
    vld_en  = (act != ACT_HOLD);
    addr_en = (act == ACT_SET);
    vld_d   = (act == ACT_SET);
    addr_d  = ll_addr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      link_vld <= 1'b0;
    end else if (vld_en) begin
      link_vld <= vld_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      link_addr <= '0;
    end else if (addr_en) begin
      link_addr <= addr_d;
    end
  end

  // R2: a set action records the address and validates it
  p_set_loads_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (act == ACT_SET) |=> (link_vld && link_addr == $past(ll_addr)));

  // R7: a clear action drops the valid flag but keeps the address
  p_clear_keeps_addr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (act == ACT_CLEAR) |=> (!link_vld && $stable(link_addr)));
endmodule

// File: rtl/resv_monitor.sv
module resv_monitor
  import resv_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int BLK_OFS_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ll_req,
  input  logic [ADDR_W-1:0] ll_addr,
  input  logic              sc_req,
  input  logic [ADDR_W-1:0] sc_addr,
  input  logic              irq,
  input  logic              inval_vld,
  input  logic [ADDR_W-1:0] inval_addr,
  output logic              sc_ack,
  output logic              sc_pass,
  output logic              st_we,
  output logic              link_vld,
  output logic [ADDR_W-1:0] link_addr
);
  logic      sc_blk_eq;
  logic      inval_blk_eq;
  resv_act_e act;

  resv_blk_cmp #(.ADDR_W(ADDR_W), .BLK_OFS_W(BLK_OFS_W)) sc_cmp_i (
    .a_addr(sc_addr), .b_addr(link_addr), .same_blk(sc_blk_eq));

  resv_blk_cmp #(.ADDR_W(ADDR_W), .BLK_OFS_W(BLK_OFS_W)) inv_cmp_i (
    .a_addr(inval_addr), .b_addr(link_addr), .same_blk(inval_blk_eq));

  resv_ctrl ctrl_i (
    .clk(clk), .rst_n(rst_n), .ll_req(ll_req), .sc_req(sc_req), .irq(irq),
    .inval_vld(inval_vld), .link_vld(link_vld), .sc_blk_eq(sc_blk_eq),
    .inval_blk_eq(inval_blk_eq), .sc_ack(sc_ack), .sc_pass(sc_pass),
    .act(act));

  resv_link_reg #(.ADDR_W(ADDR_W)) link_i (
    .clk(clk), .rst_n(rst_n), .act(act), .ll_addr(ll_addr),
    .link_vld(link_vld), .link_addr(link_addr));

  assign st_we = sc_pass;

  // R5: any store-conditional consumes the reservation
  p_sc_consumes_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (sc_req && !ll_req) |=> !link_vld);

  // R6: interrupt always clears, even with a load-linked alongside (R11)
  p_irq_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !link_vld);

  // R7: invalidation hitting the linked block clears it
  p_inval_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (inval_vld && inval_blk_eq && !ll_req) |=> !link_vld);
endmodule

// File: tb/resv_monitor_tb.sv
module resv_monitor_tb_top;
  localparam int AW = 16;
  localparam int OW = 4;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          ll_req, sc_req, irq, inval_vld;
  logic [AW-1:0] ll_addr, sc_addr, inval_addr;
  logic          sc_ack, sc_pass, st_we, link_vld;
  logic [AW-1:0] link_addr;

  int n_chk = 0;
  int n_bad = 0;
  logic c_ack, c_pass, c_we;

  always #10 clk = ~clk;

  resv_monitor #(.ADDR_W(AW), .BLK_OFS_W(OW)) dut_i (
    .clk(clk), .rst_n(rst_n), .ll_req(ll_req), .ll_addr(ll_addr),
    .sc_req(sc_req), .sc_addr(sc_addr), .irq(irq), .inval_vld(inval_vld),
    .inval_addr(inval_addr), .sc_ack(sc_ack), .sc_pass(sc_pass),
    .st_we(st_we), .link_vld(link_vld), .link_addr(link_addr));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // One cycle of stimulus; outputs sampled before the edge, state after it
  task automatic step(input logic ll, input logic [AW-1:0] lla,
                      input logic sc, input logic [AW-1:0] sca,
                      input logic ir, input logic iv, input logic [AW-1:0] iva);
    @(negedge clk);
    ll_req = ll; ll_addr = lla; sc_req = sc; sc_addr = sca;
    irq = ir; inval_vld = iv; inval_addr = iva;
    #5;
    c_ack = sc_ack; c_pass = sc_pass; c_we = st_we;
    @(posedge clk);
    #1;
    ll_req = 0; sc_req = 0; irq = 0; inval_vld = 0;
  endtask

  task automatic t_reset;
    chk("R1 vld", link_vld, 0);
    chk("R1 addr", link_addr, 0);
  endtask

  task automatic t_pass;
    step(1, 16'h1234, 0, 0, 0, 0, 0);
    chk("R2 vld", link_vld, 1);
    chk("R2 addr", link_addr, 16'h1234);
    step(0, 0, 1, 16'h123C, 0, 0, 0);
    chk("R3/R10 ack", c_ack, 1);
    chk("R3/R10 pass", c_pass, 1);
    chk("R3 we", c_we, 1);
    chk("R5 after pass", link_vld, 0);
  endtask

  task automatic t_mismatch;
    step(1, 16'h1234, 0, 0, 0, 0, 0);
    step(0, 0, 1, 16'h1244, 0, 0, 0);
    chk("R4 ack", c_ack, 1);
    chk("R4 pass", c_pass, 0);
    chk("R4 we", c_we, 0);
    chk("R5 after fail", link_vld, 0);
    step(0, 0, 1, 16'h1234, 0, 0, 0);
    chk("R4 no resv pass", c_pass, 0);
  endtask

  task automatic t_irq;
    step(1, 16'h4000, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 1, 0, 0);
    chk("R6 cleared", link_vld, 0);
    step(0, 0, 1, 16'h4000, 0, 0, 0);
    chk("R6 sc after irq", c_pass, 0);
    step(1, 16'h4000, 0, 0, 1, 0, 0);
    chk("R11 ll+irq", link_vld, 0);
    step(1, 16'h4000, 0, 0, 0, 0, 0);
    step(0, 0, 1, 16'h4000, 1, 0, 0);
    chk("R6 sc with irq", c_pass, 0);
  endtask

  task automatic t_inval;
    step(1, 16'h2000, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 1, 16'h2010);
    chk("R7 other blk vld", link_vld, 1);
    chk("R7 other blk addr", link_addr, 16'h2000);
    step(0, 0, 1, 16'h2008, 0, 0, 0);
    chk("R7 sc after miss-inval", c_pass, 1);
    step(1, 16'h2000, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 1, 16'h200F);
    chk("R7 hit clears", link_vld, 0);
    step(0, 0, 1, 16'h2000, 0, 0, 0);
    chk("R7 sc after hit", c_pass, 0);
  endtask

  task automatic t_collide;
    step(1, 16'h3330, 0, 0, 0, 0, 0);
    step(0, 0, 1, 16'h3334, 0, 1, 16'h3338);
    chk("R8 ack", c_ack, 1);
    chk("R8 pass", c_pass, 0);
    chk("R8 we", c_we, 0);
  endtask

  task automatic t_overwrite;
    step(1, 16'h1000, 0, 0, 0, 0, 0);
    step(1, 16'h5550, 0, 0, 0, 0, 0);
    chk("R9 addr", link_addr, 16'h5550);
    step(0, 0, 1, 16'h1000, 0, 0, 0);
    chk("R9 old blk", c_pass, 0);
    step(1, 16'h1000, 0, 0, 0, 0, 0);
    step(1, 16'h5550, 0, 0, 0, 0, 0);
    step(0, 0, 1, 16'h5558, 0, 0, 0);
    chk("R9 new blk", c_pass, 1);
  endtask

  task automatic t_idle;
    step(1, 16'h6000, 0, 0, 0, 0, 0);
    step(0, 0, 0, 16'h6000, 0, 0, 0);
    chk("R12 ack", c_ack, 0);
    chk("R12 pass", c_pass, 0);
    chk("R12 we", c_we, 0);
    chk("R12 resv kept", link_vld, 1);
  endtask

  initial begin
    #2000000;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 0; ll_req = 0; sc_req = 0; irq = 0; inval_vld = 0;
    ll_addr = 0; sc_addr = 0; inval_addr = 0;
    repeat (3) @(posedge clk);
    #1;
    t_reset;
    @(negedge clk);
    rst_n = 1;
    t_pass;
    t_mismatch;
    t_irq;
    t_inval;
    t_collide;
    t_overwrite;
    t_idle;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule